// File: doc/BRIEF.md
# Triggered Window-OR Hit Latch

The block keeps a rolling record of a wide bank of hit channels. It samples every channel on every clock and holds the last samples in a history shift register. When an external trigger edge arrives while the block is armed, it picks a short window of consecutive clock slots out of that history. The window starts at a programmed delay back in time. The block ORs the slots chosen by a slot mask per channel, and pushes the result into a downstream FIFO as a series of words.

A controller arms and disarms the block through two strobes and loads the delay and the slot mask through a write port. That port is honoured only while the block is disarmed. A BUSY level tells the acquisition logic when the block cannot take a trigger: it is high while disarmed and during each copy, and low while armed and idle. A trigger edge that arrives during a copy, or when the FIFO lacks room for a full record, is dropped and sets a sticky overflow flag.

Top module: `hit_window_latch`

## Requirements
- R1: On every clock edge the block samples `chan_in`. In a capture, window slot k (k = 0..5) of each channel is the sample taken delay+k+1 clock edges before the accepting edge. A slot whose index delay+k is 64 or more contributes zero.
- R2: Bit k of the slot mask enables window slot k. Each channel of the captured result is the OR of its enabled slots, so a mask of zero captures all zeros.
- R3: A rising edge on `trig_in` passes a two-flop synchroniser and an edge detector. It is accepted on the third rising clock edge after `trig_in` goes high, and only if the block is then armed, not copying, and `fifo_room` is at least 2.
- R4: A pulse on `arm` arms the block and a pulse on `disarm` disarms it; when both are high, disarm wins. A trigger edge while disarmed causes no FIFO write and does not set the overflow flag.
- R5: `busy` is high while disarmed and low while armed and idle. It goes high on the accepting clock edge and stays high for exactly 18 clock cycles.
- R6: Each accepted trigger asserts `fifo_we` for exactly two consecutive cycles. The first of these follows the accepting edge and carries captured bits 31:0; the second carries bits 63:32. `fifo_wdata` is zero whenever `fifo_we` is low.
- R7: A trigger edge that arrives while armed, but during a copy or with `fifo_room` below 2, writes nothing. It sets `ovf`, which then stays high until reset.
- R8: A `cfg_we` pulse loads `cfg_delay` and `cfg_mask` only while the block is disarmed. While armed it is ignored.
- R9: After reset the block is disarmed, `busy` is 1, `ovf` and `fifo_we` are 0, the history holds zeros, and the delay and the slot mask are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, 125 MHz |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_in | input | 64 | Channel hit levels, sampled every clock |
| trig_in | input | 1 | External trigger, asynchronous, rising edge active |
| cfg_we | input | 1 | Load strobe for delay and slot mask |
| cfg_delay | input | 6 | Window start, in clocks back in the history |
| cfg_mask | input | 6 | Slot enable mask, bit k enables slot k |
| arm | input | 1 | Arm strobe |
| disarm | input | 1 | Disarm strobe, wins over arm |
| fifo_room | input | 15 | Free entries in the downstream FIFO |
| fifo_we | output | 1 | FIFO write enable |
| fifo_wdata | output | 32 | FIFO write data |
| busy | output | 1 | High while disarmed or copying |
| ovf | output | 1 | Sticky flag for dropped trigger edges |

## Verification
A trigger raised just after one clock edge is accepted on the third edge after it. From that same edge, `busy` goes high and the low word is written. The high word follows one edge later, and `busy` falls 18 edges after acceptance. Arm, disarm and configuration writes act one edge after the strobe is seen. The bench drives every input on the falling clock edge and reads the outputs on the next falling edge, after the rising edge that responds. Its behavioural model advances on the same rising edge the design uses. Directed checks are also placed on the exact falling edges where `busy` and `fifo_we` must change after a trigger.

// File: rtl/hwl_pkg.sv
package hwl_pkg;
   localparam int HWL_NCH_DEF   = 64;
   localparam int HWL_DEPTH_DEF = 64;
   localparam int HWL_NSLOT_DEF = 6;
   localparam int HWL_WORD_DEF  = 32;
   localparam int HWL_COPY_DEF  = 18;

   typedef enum logic {
      CP_IDLE = 1'b0,
      CP_RUN  = 1'b1
   } copy_st_e;
endpackage

// File: rtl/hwl_trig_sync.sv
module hwl_trig_sync #(
   parameter int STAGES  = 2,
   parameter bit FALLING = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_in,
   output logic rise
);
   logic              lvl;
   logic [STAGES-1:0] chain_q;
   logic              last_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hwl_trig_sync: STAGES must be at least 2");
      end
      if (FALLING) begin : g_fall
         assign lvl = ~trig_in;
      end else begin : g_rise
         assign lvl = trig_in;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], lvl};
         last_q  <= chain_q[STAGES-1];
      end
   end

   assign rise = chain_q[STAGES-1] & ~last_q;

   // R3
   rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
endmodule

// File: rtl/hwl_history.sv
module hwl_history #(
   parameter int NCH   = 64,
   parameter int DEPTH = 64,
   parameter int NSLOT = 6,
   parameter int DLY_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NCH-1:0]   chan_in,
   input  logic             cfg_we,
   input  logic             cfg_lock,
   input  logic [DLY_W-1:0] cfg_delay,
   input  logic [NSLOT-1:0] cfg_mask,
   output logic [NCH-1:0]   win_or
);
   localparam int IDX_W = DLY_W + 1;
   localparam logic [IDX_W-1:0] DEPTH_L = IDX_W'(DEPTH);

   logic [NCH-1:0]   hist_q [DEPTH];
   logic [DLY_W-1:0] delay_q;
   logic [NSLOT-1:0] mask_q;
   logic [NCH-1:0]   slot_v [NSLOT];

   generate
      if (DEPTH > (1 << DLY_W)) begin : g_bad_dly
         $error("hwl_history: DLY_W too narrow for DEPTH");
      end
      if (NSLOT > DEPTH) begin : g_bad_slot
         $error("hwl_history: NSLOT exceeds DEPTH");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) hist_q[i] <= '0;
      end else begin
         hist_q[0] <= chan_in;
         for (int i = 1; i < DEPTH; i++) hist_q[i] <= hist_q[i-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         delay_q <= '0;
         mask_q  <= '0;
      end else if (cfg_we && !cfg_lock) begin
         delay_q <= cfg_delay;
         mask_q  <= cfg_mask;
      end
   end

   generate
      for (genvar k = 0; k < NSLOT; k++) begin : g_slot
         logic [IDX_W-1:0] idx;
         assign idx = {1'b0, delay_q} + IDX_W'(k);
         assign slot_v[k] = (mask_q[k] && (idx < DEPTH_L))
                            ? hist_q[idx[DLY_W-1:0]] : '0;
      end
   endgenerate

   always_comb begin
      win_or = '0;
      for (int k = 0; k < NSLOT; k++) win_or = win_or | slot_v[k];
   end

   // R8
   cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_lock |=> ($stable(delay_q) && $stable(mask_q)));
endmodule

// File: rtl/hwl_ctrl.sv
module hwl_ctrl
   import hwl_pkg::*;
#(
   parameter int NCH    = 64,
   parameter int WORD   = 32,
   parameter int COPY   = 18,
   parameter int ROOM_W = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm,
   input  logic              disarm,
   input  logic              rise,
   input  logic [ROOM_W-1:0] fifo_room,
   input  logic [NCH-1:0]    win_or,
   output logic              armed,
   output logic              fifo_we,
   output logic [WORD-1:0]   fifo_wdata,
   output logic              busy,
   output logic              ovf
);
   localparam int NWORDS = NCH / WORD;
   localparam int CNT_W  = (COPY > 1) ? $clog2(COPY) : 1;
   localparam int WSEL_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;

   copy_st_e       st_q;
   logic           armed_q;
   logic           ovf_q;
   logic [CNT_W-1:0] cnt_q;
   logic [NCH-1:0] cap_q;
   logic [WORD-1:0] word_a [NWORDS];
   logic           room_ok;
   logic           accept;
   logic           drop;

   generate
      if (COPY <= NWORDS) begin : g_bad_copy
         $error("hwl_ctrl: COPY must exceed the word count");
      end
      for (genvar w = 0; w < NWORDS; w++) begin : g_word
         assign word_a[w] = cap_q[w*WORD +: WORD];
      end
   endgenerate

   assign room_ok = (fifo_room >= ROOM_W'(NWORDS));
   assign accept  = rise && armed_q && (st_q == CP_IDLE) && room_ok;
   assign drop    = rise && armed_q && !accept;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
      end else if (disarm) begin
         armed_q <= 1'b0;
      end else if (arm) begin
         armed_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= CP_IDLE;
         cnt_q <= '0;
         cap_q <= '0;
      end else if (accept) begin
         st_q  <= CP_RUN;
         cnt_q <= '0;
         cap_q <= win_or;
      end else if (st_q == CP_RUN) begin
         if (cnt_q == CNT_W'(COPY - 1)) begin
            st_q <= CP_IDLE;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_q <= 1'b0;
      end else if (drop) begin
         ovf_q <= 1'b1;
      end
   end

   assign fifo_we    = (st_q == CP_RUN) && (cnt_q < CNT_W'(NWORDS));
   assign fifo_wdata = fifo_we ? word_a[cnt_q[WSEL_W-1:0]] : '0;
   assign busy       = !armed_q || (st_q == CP_RUN);
   assign ovf        = ovf_q;
   assign armed      = armed_q;

   // R6
   word_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_we && (cnt_q < CNT_W'(NWORDS - 1))) |=> fifo_we);
   // R6
   word_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_we && (cnt_q == CNT_W'(NWORDS - 1))) |=> !fifo_we);
   // R7
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q |=> ovf_q);
   // R4
   disarm_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      disarm |=> !armed_q);
   // R5
   busy_during_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_we |-> busy);
   // R3
   start_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_q == CP_RUN) |-> $past(armed_q));
endmodule

// File: rtl/hit_window_latch.sv
module hit_window_latch
   import hwl_pkg::*;
#(
   parameter int NCH     = HWL_NCH_DEF,
   parameter int DEPTH   = HWL_DEPTH_DEF,
   parameter int NSLOT   = HWL_NSLOT_DEF,
   parameter int WORD    = HWL_WORD_DEF,
   parameter int COPY    = HWL_COPY_DEF,
   parameter int ROOM_W  = 15,
   parameter int STAGES  = 2,
   parameter bit FALLING = 1'b0,
   localparam int DLY_W  = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NCH-1:0]    chan_in,
   input  logic              trig_in,
   input  logic              cfg_we,
   input  logic [DLY_W-1:0]  cfg_delay,
   input  logic [NSLOT-1:0]  cfg_mask,
   input  logic              arm,
   input  logic              disarm,
   input  logic [ROOM_W-1:0] fifo_room,
   output logic              fifo_we,
   output logic [WORD-1:0]   fifo_wdata,
   output logic              busy,
   output logic              ovf
);
   logic           rise;
   logic           armed;
   logic [NCH-1:0] win_or;

   generate
      if ((NCH % WORD) != 0) begin : g_bad_word
         $error("hit_window_latch: NCH must be a multiple of WORD");
      end
   endgenerate

   hwl_trig_sync #(.STAGES(STAGES), .FALLING(FALLING)) u_sync (
      .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .rise(rise)
   );

   hwl_history #(.NCH(NCH), .DEPTH(DEPTH), .NSLOT(NSLOT), .DLY_W(DLY_W)) u_hist (
      .clk(clk), .rst_n(rst_n), .chan_in(chan_in),
      .cfg_we(cfg_we), .cfg_lock(armed),
      .cfg_delay(cfg_delay), .cfg_mask(cfg_mask), .win_or(win_or)
   );

   hwl_ctrl #(.NCH(NCH), .WORD(WORD), .COPY(COPY), .ROOM_W(ROOM_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .arm(arm), .disarm(disarm), .rise(rise),
      .fifo_room(fifo_room), .win_or(win_or), .armed(armed),
      .fifo_we(fifo_we), .fifo_wdata(fifo_wdata), .busy(busy), .ovf(ovf)
   );

   // R5
   disarmed_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (disarm && !arm) |=> busy);
endmodule

// File: tb/sim_hit_window_latch.sv
module sim_hit_window_latch;
   localparam int COPY = 18;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] chan_in = '0;
   logic        trig_in = 1'b0;
   logic        cfg_we = 1'b0;
   logic [5:0]  cfg_delay = '0;
   logic [5:0]  cfg_mask = '0;
   logic        arm = 1'b0;
   logic        disarm = 1'b0;
   logic [14:0] fifo_room = 15'd100;
   logic        fifo_we;
   logic [31:0] fifo_wdata;
   logic        busy;
   logic        ovf;

   always #4 clk = ~clk;

   hit_window_latch u0 (
      .clk(clk), .rst_n(rst_n), .chan_in(chan_in), .trig_in(trig_in),
      .cfg_we(cfg_we), .cfg_delay(cfg_delay), .cfg_mask(cfg_mask),
      .arm(arm), .disarm(disarm), .fifo_room(fifo_room),
      .fifo_we(fifo_we), .fifo_wdata(fifo_wdata), .busy(busy), .ovf(ovf)
   );

   int    checks = 0;
   int    errors = 0;
   string phase = "R9";
   int    wr_cnt = 0;
   bit    hi_next = 1'b0;
   logic [63:0] last_cap = '0;
   int    mode = 0;
   int    cyc = 0;
   logic [63:0] lfsr = 64'h0123_4567_89AB_CDEF;

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp, string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
      end
   endtask

   // stimulus patterns for the channels
   always @(negedge clk) begin
      cyc <= cyc + 1;
      lfsr <= {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      if (mode == 0) chan_in <= 64'h1 << (cyc % 64);
      else           chan_in <= lfsr;
   end

   // behavioural reference model
   logic [63:0] m_hist [$];
   bit m_t1, m_t2, m_t3, m_armed, m_copy, m_ovf;
   int m_cnt, m_dly;
   logic [5:0]  m_msk;
   logic [63:0] m_cap;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_hist.delete();
         for (int i = 0; i < 64; i++) m_hist.push_back(64'h0);
         m_t1 = 0; m_t2 = 0; m_t3 = 0;
         m_armed = 0; m_copy = 0; m_ovf = 0;
         m_cnt = 0; m_dly = 0; m_msk = '0; m_cap = '0;
      end else begin
         bit rise, acc;
         logic [63:0] win;
         rise = m_t2 && !m_t3;
         win = '0;
         for (int k = 0; k < 6; k++)
            if (m_msk[k] && (m_dly + k) < 64) win = win | m_hist[m_dly + k];
         acc = rise && m_armed && !m_copy && (fifo_room >= 2);
         if (rise && m_armed && !acc) m_ovf = 1;
         if (acc) begin
            m_cap = win; m_copy = 1; m_cnt = 0;
         end else if (m_copy) begin
            if (m_cnt == COPY - 1) m_copy = 0;
            else m_cnt++;
         end
         if (cfg_we && !m_armed) begin
            m_dly = int'(cfg_delay); m_msk = cfg_mask;
         end
         if (disarm) m_armed = 0;
         else if (arm) m_armed = 1;
         m_t3 = m_t2; m_t2 = m_t1; m_t1 = trig_in;
         m_hist.push_front(chan_in);
         void'(m_hist.pop_back());
      end
   end

   // compare against the model on every falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         bit e_we;
         logic [31:0] e_data;
         e_we = m_copy && (m_cnt < 2);
         e_data = !e_we ? 32'h0 : (m_cnt == 0 ? m_cap[31:0] : m_cap[63:32]);
         chk({phase, " R5"}, 64'(busy), 64'(!m_armed || m_copy), "busy");
         chk({phase, " R6"}, 64'(fifo_we), 64'(e_we), "fifo_we");
         chk({phase, " R1 R2"}, 64'(fifo_wdata), 64'(e_data), "fifo_wdata");
         chk({phase, " R7"}, 64'(ovf), 64'(m_ovf), "ovf");
         if (fifo_we) begin
            wr_cnt++;
            if (!hi_next) last_cap[31:0] = fifo_wdata;
            else          last_cap[63:32] = fifo_wdata;
            hi_next = !hi_next;
         end
      end
   end

   task automatic pulse_trig();
      @(negedge clk) trig_in = 1'b1;
      repeat (2) @(negedge clk);
      trig_in = 1'b0;
      repeat (26) @(negedge clk);
   endtask

   task automatic strobe_arm();
      @(negedge clk) arm = 1'b1;
      @(negedge clk) arm = 1'b0;
   endtask

   task automatic strobe_disarm();
      @(negedge clk) disarm = 1'b1;
      @(negedge clk) disarm = 1'b0;
   endtask

   task automatic load_cfg(logic [5:0] d, logic [5:0] m);
      @(negedge clk) begin cfg_we = 1'b1; cfg_delay = d; cfg_mask = m; end
      @(negedge clk) cfg_we = 1'b0;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      checks++; errors++;
      $display("FAIL R3 watchdog act=timeout exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int w0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      chk("R9", 64'(busy), 64'd1, "busy after reset");
      chk("R9", 64'(ovf), 64'd0, "ovf after reset");
      chk("R9", 64'(fifo_we), 64'd0, "fifo_we after reset");
      chk("R9", 64'(fifo_wdata), 64'd0, "fifo_wdata after reset");

      // R4 trigger while disarmed
      phase = "R4";
      pulse_trig();
      chk("R4", 64'(wr_cnt), 64'd0, "writes while disarmed");
      chk("R4", 64'(ovf), 64'd0, "ovf while disarmed");

      // R3 / R5 / R6 acceptance timing
      phase = "R3";
      load_cfg(6'd0, 6'b000001);
      strobe_arm();
      chk("R5", 64'(busy), 64'd0, "busy once armed");
      w0 = wr_cnt;
      @(negedge clk) trig_in = 1'b1;
      @(negedge clk);
      @(negedge clk) trig_in = 1'b0;
      chk("R3", 64'(busy), 64'd0, "busy before third edge");
      @(negedge clk);
      chk("R3", 64'(busy), 64'd1, "busy after third edge");
      chk("R6", 64'(fifo_we), 64'd1, "first word after accept");
      repeat (17) @(negedge clk);
      chk("R5", 64'(busy), 64'd1, "busy at 17 cycles");
      @(negedge clk);
      chk("R5", 64'(busy), 64'd0, "busy released at 18 cycles");
      chk("R6", 64'(wr_cnt - w0), 64'd2, "words per trigger");
      chk("R1", 64'($countones(last_cap)), 64'd1, "single slot one-hot capture");

      // R8 config ignored while armed
      phase = "R8";
      load_cfg(6'd10, 6'b111111);
      pulse_trig();
      chk("R8", 64'($countones(last_cap)), 64'd1, "cfg write while armed ignored");

      // R1 window past the end of the history
      phase = "R1";
      strobe_disarm();
      chk("R5", 64'(busy), 64'd1, "busy when disarmed");
      load_cfg(6'd60, 6'b111111);
      strobe_arm();
      pulse_trig();
      chk("R1", 64'($countones(last_cap)), 64'd4, "slots beyond 63 read zero");

      // R2 mask zero, then sparse mask on random data
      phase = "R2";
      strobe_disarm();
      load_cfg(6'd5, 6'b000000);
      strobe_arm();
      last_cap = '1;
      pulse_trig();
      chk("R2", last_cap, 64'h0, "empty mask captures zero");
      strobe_disarm();
      mode = 1;
      load_cfg(6'd3, 6'b010101);
      strobe_arm();
      pulse_trig();
      pulse_trig();

      // R7 overflow cases
      phase = "R7";
      w0 = wr_cnt;
      @(negedge clk) trig_in = 1'b1;
      repeat (2) @(negedge clk);
      trig_in = 1'b0;
      repeat (4) @(negedge clk);
      trig_in = 1'b1;
      repeat (2) @(negedge clk);
      trig_in = 1'b0;
      repeat (26) @(negedge clk);
      chk("R7", 64'(ovf), 64'd1, "trigger during copy sets ovf");
      chk("R7", 64'(wr_cnt - w0), 64'd2, "dropped trigger writes nothing");
      fifo_room = 15'd1;
      w0 = wr_cnt;
      pulse_trig();
      chk("R7", 64'(wr_cnt - w0), 64'd0, "no write when room below 2");
      fifo_room = 15'd100;
      strobe_disarm();
      repeat (2) @(negedge clk);
      chk("R7", 64'(ovf), 64'd1, "ovf stays set");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule